// File: doc/BRIEF.md
# GPIO Pin State Resolver

This block settles, for every pin of a general purpose I/O port, two things at once: the value the input bit reads back, and whether the pin's own output driver is driving the pad and at what level. It works from three inputs for each pin. The first is a configuration word, which sets the direction, the input-buffer disconnect, the pull resistor and the drive mode. The second is the pin's output bit. The third is an external stimulus, which either drives a level onto the pin or leaves it undriven.

The output drive is resolved combinationally. The input bit, a sticky short-circuit vector and the last recorded drive state are held in registers that update on every clock. A change strobe compares the present resolved drive (the valid flag and the level) with the recorded copy. It goes high in every cycle in which the two differ, so a downstream consumer can forward only real transitions of the pad driver.

Top module: `gpio_pin_resolver`

## Requirements
- R1: The drive mode is configuration bits 10:8. Codes 0 to 3 let the driver drive at both levels. Codes 4 and 5 let it drive only while the output bit is 1. Codes 6 and 7 let it drive only while the output bit is 0.
- R2: The internal driver is active only when the drive-mode check passes and the direction bit (configuration bit 0) is 1. With direction 0 and no pull forcing, `out_vld_o` is 0.
- R3: The pull field is configuration bits 3:2. Code 1 is a pull-down with level 0, code 3 is a pull-up with level 1, and codes 0 and 2 mean no pull.
- R4: When configuration bit 1 is 1, the input buffer is disconnected and the external stimulus has no effect. If a pull is enabled, `in_o` takes the pull level at the next edge. With no pull, `in_o` keeps its value.
- R5: When the buffer is connected and the external stimulus drives, `in_o` takes the stimulus level at the next edge.
- R6: When the buffer is connected, the stimulus is undriven, a pull is enabled and the internal driver is inactive, the output is reported as valid at the pull level. When the buffer is connected, the stimulus is undriven and the output is valid, `in_o` takes `out_val_o` at the next edge. Otherwise `in_o` holds. When the output is not forced by a pull, `out_val_o` equals the output bit.
- R7: A pin's bit in `short_o` is set at the next edge when the buffer is connected, the internal driver is active, the stimulus drives and the two levels differ. Once set, the bit stays set until reset.
- R8: `evt_o` for a pin is 1 exactly when its present valid flag or level differs from the values recorded at the last edge. The recorded values are captured at every edge.
- R9: Reset clears `in_o`, `short_o` and the recorded valid flags and levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | PINS*CFG_W | Configuration words, pin n at bits n*CFG_W upward |
| out_i | input | PINS | Output bit of each pin |
| ext_drv_i | input | PINS | External stimulus drives the pin |
| ext_lvl_i | input | PINS | Level of the external stimulus |
| in_o | output | PINS | Registered effective input bits |
| out_val_o | output | PINS | Resolved output level |
| out_vld_o | output | PINS | Resolved output is driving |
| evt_o | output | PINS | Drive state differs from the recorded state |
| short_o | output | PINS | Sticky short-circuit flags |

## Verification
The assertions check the following in every cycle. The strobe is quiet once the resolved drive has stayed unchanged for a clock. Short bits never clear on their own, and a new short bit needs an external driver in the cycle before. A disconnected buffer holds `in_o` when no pull is enabled and loads the pull level when one is. The bench's scenarios are needed for the rest: the exact gating of each drive-mode code, the pull-code decoding, pull forcing of the output, and `in_o` following either the stimulus or the resolved output. These are checked against a pin-by-pin model under random configurations and directed corner cases.

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver #(
  parameter int PINS  = 32,
  parameter int CFG_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PINS*CFG_W-1:0] cfg_i,
  input  logic [PINS-1:0]       out_i,
  input  logic [PINS-1:0]       ext_drv_i,
  input  logic [PINS-1:0]       ext_lvl_i,
  output logic [PINS-1:0]       in_o,
  output logic [PINS-1:0]       out_val_o,
  output logic [PINS-1:0]       out_vld_o,
  output logic [PINS-1:0]       evt_o,
  output logic [PINS-1:0]       short_o
);
  localparam logic [1:0] PULL_DN = 2'd1;
  localparam logic [1:0] PULL_UP = 2'd3;

  logic [PINS-1:0] in_nxt, hit, keep_m, pull_m, pull_l, disc_m;
  logic [PINS-1:0] rec_val, rec_vld;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [CFG_W-1:0] c;
    logic             gate, drv, pull_en, force_pull;
    assign c          = cfg_i[i*CFG_W +: CFG_W];
    assign gate       = c[10] ? (c[9] ? ~out_i[i] : out_i[i]) : 1'b1;
    assign drv        = gate & c[0];
    assign pull_en    = (c[3:2] == PULL_DN) | (c[3:2] == PULL_UP);
    assign force_pull = ~c[1] & ~ext_drv_i[i] & pull_en & ~drv;
    assign out_vld_o[i] = drv | force_pull;
    assign out_val_o[i] = force_pull ? c[3] : out_i[i];
    assign hit[i]     = ~c[1] & drv & ext_drv_i[i] & (out_i[i] ^ ext_lvl_i[i]);
    assign keep_m[i]  = c[1] & ~pull_en;
    assign pull_m[i]  = c[1] & pull_en;
    assign pull_l[i]  = c[3];
    assign disc_m[i]  = c[1];
    always_comb begin
      if (c[1])                in_nxt[i] = pull_en ? c[3] : in_o[i];
      else if (ext_drv_i[i])   in_nxt[i] = ext_lvl_i[i];
      else if (out_vld_o[i])   in_nxt[i] = out_val_o[i];
      else                     in_nxt[i] = in_o[i];
    end
  end

  assign evt_o = (out_vld_o ^ rec_vld) | (out_val_o ^ rec_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_o    <= '0;
      short_o <= '0;
      rec_val <= '0;
      rec_vld <= '0;
    end else begin
      in_o    <= in_nxt;
      short_o <= short_o | hit;
      rec_val <= out_val_o;
      rec_vld <= out_vld_o;
    end
  end

  AST_EVT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(out_vld_o) && $stable(out_val_o)) |-> (evt_o == '0)); // R8

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((short_o & $past(short_o)) == $past(short_o))); // R7

  AST_SHORT_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((short_o & ~$past(short_o) & ~$past(ext_drv_i)) == '0)); // R7

  AST_DISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((in_o ^ $past(in_o)) & $past(keep_m)) == '0)); // R4

  AST_DISC_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((in_o ^ $past(pull_l)) & $past(pull_m)) == '0)); // R4

  AST_DISC_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((short_o & ~$past(short_o) & $past(disc_m)) == '0)); // R4
endmodule

// File: tb/gpio_pin_resolver_test.sv
module gpio_pin_resolver_test;
  localparam int P = 32;
  localparam int W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P*W-1:0] cfg = '0;
  logic [P-1:0] outv = '0, edrv = '0, elvl = '0;
  logic [P-1:0] in_o, out_val_o, out_vld_o, evt_o, short_o;
  logic [P-1:0] m_in, m_sh, m_rval, m_rvld;
  logic [P-1:0] e_vld, e_val, e_in, e_hit;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_pin_resolver #(.PINS(P), .CFG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .out_i(outv),
    .ext_drv_i(edrv), .ext_lvl_i(elvl), .in_o(in_o),
    .out_val_o(out_val_o), .out_vld_o(out_vld_o),
    .evt_o(evt_o), .short_o(short_o));

  function automatic logic [W-1:0] mk(int mode, int pull, bit disc, bit dir);
    logic [W-1:0] c = '0;
    c[10:8] = mode[2:0]; c[3:2] = pull[1:0]; c[1] = disc; c[0] = dir;
    return c;
  endfunction

  task automatic eval();
    for (int i = 0; i < P; i++) begin
      logic [W-1:0] c;
      bit on, pe, pl, frc;
      c  = cfg[i*W +: W];
      case (c[10:8])
        3'd4, 3'd5: on = outv[i];
        3'd6, 3'd7: on = !outv[i];
        default:    on = 1;
      endcase
      on  = on && c[0];
      pe  = (c[3:2] == 2'd1) || (c[3:2] == 2'd3);
      pl  = (c[3:2] == 2'd3);
      frc = !c[1] && !edrv[i] && pe && !on;
      e_vld[i] = on || frc;
      e_val[i] = frc ? pl : outv[i];
      e_hit[i] = !c[1] && on && edrv[i] && (outv[i] != elvl[i]);
      if (c[1]) e_in[i] = pe ? pl : m_in[i];
      else if (edrv[i]) e_in[i] = elvl[i];
      else if (e_vld[i]) e_in[i] = e_val[i];
      else e_in[i] = m_in[i];
    end
  endtask

  task automatic chk(string tag, string what, logic [P-1:0] got, logic [P-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag);
    #2;
    eval();
    chk(tag, "out_vld (R1 R2 R6)", out_vld_o, e_vld);
    chk(tag, "out_val (R3 R6)", out_val_o, e_val);
    chk(tag, "evt (R8)", evt_o, (e_vld ^ m_rvld) | (e_val ^ m_rval));
    chk(tag, "in (R4 R5 R6)", in_o, m_in);
    chk(tag, "short (R7)", short_o, m_sh);
    @(posedge clk);
    m_in = e_in; m_sh = m_sh | e_hit; m_rval = e_val; m_rvld = e_vld;
    @(negedge clk);
  endtask

  task automatic all_cfg(int mode, int pull, bit disc, bit dir);
    for (int i = 0; i < P; i++) cfg[i*W +: W] = mk(mode, pull, disc, dir);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_in = '0; m_sh = '0; m_rval = '0; m_rvld = '0;
    repeat (3) @(negedge clk);
    chk("R9", "in at reset", in_o, '0);
    chk("R9", "short at reset", short_o, '0);
    chk("R9", "evt at reset", evt_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: direction 0, no pull, nothing drives
    all_cfg(0, 0, 0, 0); outv = '1; step("R2");
    step("R2");
    // R1: drive-mode codes against both output levels
    for (int m = 0; m < 8; m++) begin
      all_cfg(m, 0, 0, 1);
      outv = 32'hA5A5_0F0F; step("R1");
      outv = ~outv;         step("R1");
    end
    // R3: every pull code on a floating connected pin
    for (int p = 0; p < 4; p++) begin
      all_cfg(0, p, 0, 0); outv = '0; edrv = '0; step("R3");
    end
    // R5: external levels drive IN
    all_cfg(0, 0, 0, 0); edrv = '1; elvl = 32'h1234_5678; step("R5");
    step("R5");
    // R4: disconnected buffer without pull ignores the stimulus
    all_cfg(0, 0, 1, 0); elvl = ~elvl; step("R4");
    elvl = '0; step("R4"); elvl = '1; step("R4");
    // R4: disconnected buffer with pull-up, then pull-down
    all_cfg(0, 3, 1, 0); step("R4"); step("R4");
    all_cfg(0, 1, 1, 0); step("R4"); step("R4");
    // R6: push-pull output followed by IN when floating
    all_cfg(0, 0, 0, 1); edrv = '0; outv = 32'hF0F0_F0F0; step("R6"); step("R6");
    // R7: conflict, then removal; short stays
    edrv = '1; elvl = ~outv; step("R7"); step("R7");
    edrv = '0; step("R7"); step("R7");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < P; i++)
        cfg[i*W +: W] = mk($urandom_range(0, 7), $urandom_range(0, 3),
                           ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
      outv = $urandom(); edrv = $urandom(); elvl = $urandom();
      step("R1/R2/R3/R4/R5/R6/R7/R8");
      if ($urandom_range(0, 3) == 0) step("R8");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule